// File: doc/BRIEF.md
# Descriptor-Ring Playback DMA Channel

This block is one bus-master playback channel. It walks a circular ring of 32 buffer descriptors held in system memory, reads 16-bit samples from the buffers those descriptors point to, and delivers them in order on a valid/ready sample stream toward an output FIFO. Memory is reached through a single-outstanding request/response read port. Software drives the channel through a small word-addressed register port and is told about events by one level interrupt line.

Software sets up the channel in this order. It writes the ring base, sets the current index to 0, and sets the last-valid index to the entry just before the next free one. It then sets the global start bit for the channel slot and the run bit. Playback proceeds until the descriptor at the last-valid index has finished. Software keeps the stream going by refilling entries and moving the last-valid index forward. To halt, software sets pause, clears start, and writes zero to the control register. It then polls the control register until it reads zero, and finally issues a register reset.

Top module: `audio_ring_dma`

## Requirements
- R1: After reset, every register reads zero, `irq`, `mem_req` and `smp_valid` are low.
- R2: Descriptor n occupies two words at ring base + 8*n. The first word is the buffer byte address. The second word holds the sample count in bits 15:0 and the completion-interrupt flag in bit 31. Samples are 2 bytes and are output in address order. The sample at byte address a is taken from the word at a with bits 1:0 cleared: bits 15:0 when a[1]=0, bits 31:16 when a[1]=1.
- R3: When a descriptor other than the last-valid one finishes, the current index (register 1) advances by one modulo 32. When the descriptor at the last-valid index (register 2) finishes, the index stays put, fetching stops, status bit 2 (last-buffer) sets and status bit 0 (ended) reads 1. If the last-valid index is then changed, the engine advances and resumes.
- R4: Memory requests are issued only while the control run bit (bit 0 of register 3) is set, the global start bit at position SLOT of register 8 is set, and the pause bit at position SLOT+16 of register 8 is clear. Under pause the position is held, and clearing pause resumes playback.
- R5: While `smp_valid` is high and `smp_ready` is low, `smp_valid` stays high and `smp_data` is unchanged.
- R6: Completing a descriptor whose bit 31 flag is set sets status bit 3 (completion).
- R7: Status bits 4:2 (register 4) are cleared by writing one. Any channel event sets bit SLOT of the global interrupt status register (register 9), which is also cleared by writing one.
- R8: While the engine is ended and running, `smp_ready` high with no sample available sets status bit 4 (underrun). With `smp_ready` low it does not.
- R9: `irq` is high exactly when some status bit among 4:2 is set together with its enable at the same position in control register 3 (bit 2 last-buffer, bit 3 completion, bit 4 underrun).
- R10: After run is cleared, control bit 0 reads 1 until the engine is idle (an outstanding read finishes first) and then reads 0. After that no sample or memory request appears.
- R11: Writing control bit 1 (register reset) clears the current index, status bits and sample position one cycle later. The bit reads 0 again from the following cycle on.
- R12: A descriptor with a sample count of 0 completes, with its status effects, without outputting any sample.
- R13: The current index can be written only while the engine is idle; writes while busy are ignored. Writes to the last-valid index keep only the low 5 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Word-aligned read byte address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| smp_valid | output | 1 | Sample available |
| smp_ready | input | 1 | Sample accepted by the consumer |
| smp_data | output | 16 | Sample value |
| irq | output | 1 | Level interrupt |

## Verification
The ring is driven with short descriptors of mixed lengths, odd half-word start addresses, a zero-length entry and a wrap from index 31 to 0. The resulting sample sequence is compared against values computed from byte addresses, which separates lane-selection errors from index-stepping errors. The consumer is run with ready held high, with a periodic two-of-three ready pattern and with ready held low. This distinguishes correct holding under backpressure from dropped or repeated samples, and shows that the underrun flag responds only to real demand. Pause, a cleared start bit, the refill of the last-valid index, the halt poll and the register reset are each applied mid-run, and the sample count is observed before and after.

// File: rtl/aring_pkg.sv
package aring_pkg;

    // Register word addresses
    localparam logic [3:0] RA_BASE  = 4'h0;
    localparam logic [3:0] RA_CUR   = 4'h1;
    localparam logic [3:0] RA_LAST  = 4'h2;
    localparam logic [3:0] RA_CTRL  = 4'h3;
    localparam logic [3:0] RA_STAT  = 4'h4;
    localparam logic [3:0] RA_GCTRL = 4'h8;
    localparam logic [3:0] RA_GINT  = 4'h9;

    localparam int PAUSE_OFS  = 16;  // pause bit sits this far above start
    localparam int DESC_BYTES = 8;   // two words per descriptor

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_D0_REQ,
        ST_D0_WAIT,
        ST_D1_REQ,
        ST_D1_WAIT,
        ST_S_REQ,
        ST_S_WAIT,
        ST_PUSH,
        ST_DONE,
        ST_ENDED
    } eng_state_e;

    // Channel control byte, LSB first: run, reset-regs, lvb/ioc/fe enables
    typedef struct packed {
        logic fe_ie;
        logic ioc_ie;
        logic lvb_ie;
        logic rr;
        logic run;
    } ctrl_t;

    // Sticky event bits (status bits 4:2)
    typedef struct packed {
        logic fe;
        logic ioc;
        logic lvb;
    } evt_t;

    function automatic logic [15:0] pick_lane(input logic [31:0] word,
                                              input logic hi);
        return hi ? word[31:16] : word[15:0];
    endfunction

endpackage

// File: rtl/aring_regs.sv
module aring_regs
    import aring_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int AW    = 32,
    parameter int SLOT  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic             busy,
    input  logic             ended,
    input  evt_t             ev,
    output logic [AW-1:0]    base_addr,
    output logic [IDX_W-1:0] last_idx,
    output logic             run,
    output logic             go,
    output logic             rr_pulse,
    output logic             cur_load,
    output logic [IDX_W-1:0] cur_load_val,
    output logic             irq
);
    localparam int PBIT = SLOT + PAUSE_OFS;

    ctrl_t            ctrl_q;
    evt_t             sts_q;
    logic             start_q, pause_q, gint_q;
    logic [AW-1:0]    base_q;
    logic [IDX_W-1:0] last_q;

    logic wr_base, wr_last, wr_ctrl, wr_stat, wr_gctrl, wr_gint;
    assign wr_base  = reg_we && reg_addr == RA_BASE;
    assign wr_last  = reg_we && reg_addr == RA_LAST;
    assign wr_ctrl  = reg_we && reg_addr == RA_CTRL;
    assign wr_stat  = reg_we && reg_addr == RA_STAT;
    assign wr_gctrl = reg_we && reg_addr == RA_GCTRL;
    assign wr_gint  = reg_we && reg_addr == RA_GINT;

    evt_t w1c;
    assign w1c = wr_stat ? evt_t'(reg_wdata[4:2]) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            sts_q   <= '0;
            start_q <= 1'b0;
            pause_q <= 1'b0;
            gint_q  <= 1'b0;
            base_q  <= '0;
            last_q  <= '0;
        end else begin
            if (wr_base) base_q <= reg_wdata[AW-1:0];
            if (wr_last) last_q <= reg_wdata[IDX_W-1:0];
            if (wr_ctrl)        ctrl_q    <= ctrl_t'(reg_wdata[4:0]);
            else if (ctrl_q.rr) ctrl_q.rr <= 1'b0;
            if (wr_gctrl) begin
                start_q <= reg_wdata[SLOT];
                pause_q <= reg_wdata[PBIT];
            end
            if (ctrl_q.rr) sts_q <= '0;
            else           sts_q <= (sts_q & ~w1c) | ev;
            if (|ev)                          gint_q <= 1'b1;
            else if (wr_gint && reg_wdata[SLOT]) gint_q <= 1'b0;
        end
    end

    assign base_addr    = base_q;
    assign last_idx     = last_q;
    assign run          = ctrl_q.run;
    assign rr_pulse     = ctrl_q.rr;
    assign go           = ctrl_q.run && start_q && !pause_q && !ctrl_q.rr;
    assign cur_load     = reg_we && reg_addr == RA_CUR && !busy;
    assign cur_load_val = reg_wdata[IDX_W-1:0];
    assign irq          = |(sts_q & {ctrl_q.fe_ie, ctrl_q.ioc_ie, ctrl_q.lvb_ie});

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_BASE:  reg_rdata[AW-1:0]    = base_q;
            RA_CUR:   reg_rdata[IDX_W-1:0] = cur_idx;
            RA_LAST:  reg_rdata[IDX_W-1:0] = last_q;
            RA_CTRL:  reg_rdata[4:0] = {ctrl_q.fe_ie, ctrl_q.ioc_ie, ctrl_q.lvb_ie,
                                        ctrl_q.rr, ctrl_q.run | busy};
            RA_STAT:  reg_rdata[4:0] = {sts_q, 1'b0, ended};
            RA_GCTRL: begin
                reg_rdata[SLOT] = start_q;
                reg_rdata[PBIT] = pause_q;
            end
            RA_GINT:  reg_rdata[SLOT] = gint_q;
            default:  reg_rdata = '0;
        endcase
    end

    // R11: the reset-registers bit lives for exactly one cycle
    a_r11_rr_selfclear: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.rr && !(wr_ctrl && reg_wdata[1]) |=> !ctrl_q.rr);

    // R11: status is empty right after a register reset
    a_r11_rr_clears_status: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.rr |=> sts_q == '0);

    // R7: a set status bit stays set unless cleared by write-one or reset
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        sts_q.lvb && !wr_stat && !ctrl_q.rr |=> sts_q.lvb);

endmodule

// File: rtl/aring_fetch.sv
module aring_fetch
    import aring_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int AW    = 32,
    parameter int LEN_W = 16,
    parameter int SW    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             run,
    input  logic             rr_pulse,
    input  logic [AW-1:0]    base_addr,
    input  logic [IDX_W-1:0] last_idx,
    input  logic             cur_load,
    input  logic [IDX_W-1:0] cur_load_val,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_rvalid,
    input  logic [2*SW-1:0]  mem_rdata,
    output logic             smp_valid,
    input  logic             smp_ready,
    output logic [SW-1:0]    smp_data,
    output logic [IDX_W-1:0] cur_idx,
    output logic             busy,
    output logic             ended,
    output evt_t             ev
);
    localparam int DW  = 2 * SW;
    localparam int DSH = $clog2(DESC_BYTES);

    eng_state_e       st_q;
    logic [IDX_W-1:0] cur_q;
    logic [AW-1:0]    buf_q;
    logic [LEN_W-1:0] len_q, cnt_q;
    logic             ioc_q, half_q;
    logic [SW-1:0]    smp_q;

    logic [AW-1:0]    desc_addr, smp_addr;
    logic [LEN_W-1:0] cnt_nx;
    logic             at_last, is_req;

    assign desc_addr = base_addr + (AW'(cur_q) << DSH);
    assign smp_addr  = buf_q + (AW'(cnt_q) << 1);
    assign cnt_nx    = cnt_q + 1'b1;
    assign at_last   = cur_q == last_idx;
    assign is_req    = st_q == ST_D0_REQ || st_q == ST_D1_REQ || st_q == ST_S_REQ;

    always_comb begin
        case (st_q)
            ST_D0_REQ: mem_addr = desc_addr;
            ST_D1_REQ: mem_addr = desc_addr + AW'(4);
            default:   mem_addr = smp_addr & ~AW'(3);
        endcase
    end

    assign mem_req   = is_req && go;
    assign smp_valid = st_q == ST_PUSH && run;
    assign smp_data  = smp_q;
    assign cur_idx   = cur_q;
    assign busy      = st_q != ST_IDLE;
    assign ended     = st_q == ST_ENDED;

    always_comb begin
        ev     = '0;
        ev.ioc = st_q == ST_DONE && ioc_q;
        ev.lvb = st_q == ST_DONE && at_last;
        ev.fe  = st_q == ST_ENDED && run && smp_ready;
    end

    always_ff @(posedge clk) begin
        if (rst || rr_pulse) begin
            st_q   <= ST_IDLE;
            cur_q  <= '0;
            buf_q  <= '0;
            len_q  <= '0;
            cnt_q  <= '0;
            ioc_q  <= 1'b0;
            half_q <= 1'b0;
            smp_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (cur_load)  cur_q <= cur_load_val;
                    else if (go)   st_q  <= ST_D0_REQ;
                end
                ST_D0_REQ, ST_D1_REQ, ST_S_REQ: begin
                    if (!run) st_q <= ST_IDLE;
                    else if (go) begin
                        if (st_q == ST_S_REQ) half_q <= smp_addr[1];
                        st_q <= (st_q == ST_D0_REQ) ? ST_D0_WAIT :
                                (st_q == ST_D1_REQ) ? ST_D1_WAIT : ST_S_WAIT;
                    end
                end
                ST_D0_WAIT: if (mem_rvalid) begin
                    buf_q <= mem_rdata[AW-1:0];
                    st_q  <= run ? ST_D1_REQ : ST_IDLE;
                end
                ST_D1_WAIT: if (mem_rvalid) begin
                    len_q <= mem_rdata[LEN_W-1:0];
                    ioc_q <= mem_rdata[DW-1];
                    cnt_q <= '0;
                    if (!run)                            st_q <= ST_IDLE;
                    else if (mem_rdata[LEN_W-1:0] == '0) st_q <= ST_DONE;
                    else                                 st_q <= ST_S_REQ;
                end
                ST_S_WAIT: if (mem_rvalid) begin
                    smp_q <= pick_lane(mem_rdata, half_q);
                    st_q  <= run ? ST_PUSH : ST_IDLE;
                end
                ST_PUSH: begin
                    if (!run) st_q <= ST_IDLE;
                    else if (smp_ready) begin
                        cnt_q <= cnt_nx;
                        st_q  <= (cnt_nx == len_q) ? ST_DONE : ST_S_REQ;
                    end
                end
                ST_DONE: begin
                    if (at_last) st_q <= ST_ENDED;
                    else begin
                        cur_q <= cur_q + 1'b1;
                        st_q  <= ST_D0_REQ;
                    end
                end
                ST_ENDED: begin
                    if (!run) st_q <= ST_IDLE;
                    else if (!at_last) begin
                        cur_q <= cur_q + 1'b1;
                        st_q  <= ST_D0_REQ;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R5: an offered sample is held until taken (or the channel stops)
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        smp_valid && !smp_ready |=> (smp_valid && $stable(smp_data)) || !run);

    // R4: no request leaves unless the channel is allowed to fetch
    a_r4_req_gated: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> go);

    // R4: one outstanding read at a time
    a_r4_single: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R3: the index only holds or steps by one
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        !rr_pulse && !cur_load |=>
        (cur_q == $past(cur_q)) || (cur_q == IDX_W'($past(cur_q) + 1'b1)));

    // R11: register reset returns the engine to idle at index 0
    a_r11_idle: assert property (@(posedge clk) disable iff (rst)
        rr_pulse |=> cur_q == '0 && !busy);

endmodule

// File: rtl/audio_ring_dma.sv
module audio_ring_dma
    import aring_pkg::*;
#(
    parameter int SLOT  = 1,
    parameter int IDX_W = 5,
    parameter int LEN_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        smp_valid,
    input  logic        smp_ready,
    output logic [15:0] smp_data,
    output logic        irq
);
    localparam int AW = 32;
    localparam int SW = 16;

    logic [IDX_W-1:0] cur_idx, last_idx, cur_load_val;
    logic [AW-1:0]    base_addr;
    logic             busy, ended, run, go, rr_pulse, cur_load;
    evt_t             ev;

    aring_regs #(.IDX_W(IDX_W), .AW(AW), .SLOT(SLOT)) regs_i (
        .clk, .rst, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .cur_idx, .busy, .ended, .ev,
        .base_addr, .last_idx, .run, .go, .rr_pulse,
        .cur_load, .cur_load_val, .irq
    );

    aring_fetch #(.IDX_W(IDX_W), .AW(AW), .LEN_W(LEN_W), .SW(SW)) fetch_i (
        .clk, .rst, .go, .run, .rr_pulse, .base_addr, .last_idx,
        .cur_load, .cur_load_val,
        .mem_req, .mem_addr, .mem_rvalid, .mem_rdata,
        .smp_valid, .smp_ready, .smp_data,
        .cur_idx, .busy, .ended, .ev
    );

endmodule

// File: tb/audio_ring_dma_tb_top.sv
`timescale 1ns/1ps
module audio_ring_dma_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        smp_valid;
    logic        smp_ready = 1'b0;
    logic [15:0] smp_data;
    logic        irq;

    always #2.5 clk = ~clk;

    audio_ring_dma dut_i (.*);

    int nchk = 0, nerr = 0;
    logic [31:0] mem [0:511];
    logic [15:0] got [0:255];
    logic [15:0] expv [0:255];
    int ng = 0, ne = 0;
    int rmode = 2, cyc = 0, lat = 0;
    logic [31:0] pend = '0;

    function automatic logic [15:0] fval(input logic [31:0] a);
        return 16'h5000 | 16'((a >> 1) & 32'hFFF);
    endfunction

    // memory model: response two negedges after the request
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (lat == 1) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem[pend[10:2]];
        end
        if (lat > 0) lat--;
        if (mem_req) begin
            pend = mem_addr;
            lat  = 2;
        end
    end

    // consumer: choose ready, record what the next edge will take
    always @(negedge clk) begin
        cyc++;
        case (rmode)
            0: smp_ready = 1'b1;
            1: smp_ready = (cyc % 3) != 2;
            default: smp_ready = 1'b0;
        endcase
        if (smp_valid && smp_ready && ng < 256) begin
            got[ng] = smp_data;
            ng++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic setd(input int idx, input logic [31:0] bufa, input int len, input logic ioc);
        mem[idx*2]     = bufa;
        mem[idx*2 + 1] = {ioc, 15'b0, 16'(len)};
        for (int k = 0; k < len; k++) begin
            expv[ne] = fval(bufa + 32'(2*k));
            ne++;
        end
    endtask

    task automatic cmp_stream(input string tag);
        int bad = -1;
        for (int i = 0; i < ng; i++)
            if (bad < 0 && got[i] !== expv[i]) bad = i;
        if (bad < 0) chk(tag, 32'(ng), 32'(ng));
        else chk(tag, 32'(got[bad]), 32'(expv[bad]));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic finished = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n0, polls;
        for (int w = 0; w < 512; w++)
            mem[w] = {fval(32'(4*w + 2)), fval(32'(4*w))};
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rd(4'h1, v); chk("R1 cur", v, 0);
        rd(4'h3, v); chk("R1 ctrl", v, 0);
        rd(4'h4, v); chk("R1 status", v, 0);
        rd(4'h8, v); chk("R1 gctrl", v, 0);
        chk("R1 outputs", {29'b0, irq, mem_req, smp_valid}, 0);

        // R2/R3/R6: three descriptors, odd lane start, backpressure
        setd(0, 32'h200, 3, 1'b0);
        setd(1, 32'h206, 1, 1'b1);
        setd(2, 32'h300, 4, 1'b0);
        rmode = 1;
        wr(4'h0, 32'h0);
        wr(4'h2, 32'd2);
        wr(4'h8, 32'h2);
        wr(4'h3, 32'h0D);
        idle(150);
        chk("R2 count", 32'(ng), 8);
        cmp_stream("R2 R5 sample order");
        rmode = 2;
        idle(2);
        rd(4'h1, v); chk("R3 cur at last", v, 2);
        rd(4'h4, v); chk("R3 R6 R8 status", v, 32'h1D);
        chk("R9 irq set", {31'b0, irq}, 1);
        rd(4'h9, v); chk("R7 global int", v, 32'h2);

        // R7/R9 write-one-to-clear
        wr(4'h4, 32'h04);
        rd(4'h4, v); chk("R7 clear lvb", v, 32'h19);
        chk("R9 irq from ioc", {31'b0, irq}, 1);
        wr(4'h4, 32'h18);
        rd(4'h4, v); chk("R7 clear rest", v, 32'h01);
        chk("R9 irq low", {31'b0, irq}, 0);
        wr(4'h9, 32'h2);
        rd(4'h9, v); chk("R7 global clear", v, 0);

        // R8 underrun only under demand
        wr(4'h3, 32'h1D);
        rmode = 0; idle(3);
        rd(4'h4, v); chk("R8 underrun set", v, 32'h11);
        chk("R9 irq fe", {31'b0, irq}, 1);
        rmode = 2; idle(1);
        wr(4'h4, 32'h10); idle(3);
        rd(4'h4, v); chk("R8 no demand", v, 32'h01);

        // R4 pause holds, R3 refill resumes
        wr(4'h3, 32'h01);
        wr(4'h8, 32'h2 | (32'h1 << 17));
        setd(3, 32'h400, 2, 1'b0);
        rmode = 0;
        wr(4'h2, 32'd3);
        idle(50);
        chk("R4 paused no output", 32'(ng), 8);
        wr(4'h8, 32'h2);
        idle(50);
        chk("R3 refill count", 32'(ng), 10);
        rd(4'h1, v); chk("R3 cur advanced", v, 3);

        // R4 start clear
        wr(4'h8, 32'h0);
        setd(4, 32'h480, 2, 1'b0);
        wr(4'h2, 32'd4);
        idle(40);
        chk("R4 no start no output", 32'(ng), 10);
        wr(4'h8, 32'h2);
        idle(50);
        chk("R4 resumed", 32'(ng), 12);

        // R12 zero-length descriptor
        wr(4'h4, 32'h1C);
        setd(5, 32'h500, 0, 1'b1);
        setd(6, 32'h510, 2, 1'b0);
        wr(4'h2, 32'd6);
        idle(60);
        chk("R12 count", 32'(ng), 14);
        rd(4'h4, v); chk("R12 ioc from empty", v & 32'h8, 32'h8);
        rd(4'h1, v); chk("R3 cur 6", v, 6);
        cmp_stream("R12 stream");

        // R10 halt handshake, R11 register reset
        setd(7, 32'h600, 40, 1'b0);
        rmode = 1;
        wr(4'h2, 32'd7);
        idle(30);
        wr(4'h8, 32'h2 | (32'h1 << 17));
        wr(4'h8, 32'h1 << 17);
        wr(4'h3, 32'h0);
        polls = 0;
        do begin
            rd(4'h3, v);
            polls++;
        end while ((v & 1) != 0 && polls < 20);
        chk("R10 ctrl reads zero", v, 0);
        n0 = ng;
        idle(20);
        chk("R10 no output after halt", 32'(ng), 32'(n0));
        chk("R10 quiet ports", {30'b0, mem_req, smp_valid}, 0);
        ne = ng;
        wr(4'h3, 32'h02);
        rd(4'h3, v); chk("R11 rr self clear", v, 0);
        rd(4'h1, v); chk("R11 cur cleared", v, 0);
        rd(4'h4, v); chk("R11 status cleared", v, 0);

        // R13 index writes, R3 wrap 31 -> 0
        wr(4'h1, 32'd31);
        rd(4'h1, v); chk("R13 cur write idle", v, 31);
        wr(4'h2, 32'h20);
        rd(4'h2, v); chk("R13 last masked", v, 0);
        setd(31, 32'h700, 2, 1'b1);
        setd(0, 32'h722, 3, 1'b0);
        wr(4'h8, 32'h2);
        wr(4'h3, 32'h01);
        idle(80);
        chk("R3 wrap count", 32'(ng), 32'(ne));
        rd(4'h1, v); chk("R3 wrap cur", v, 0);
        rd(4'h4, v); chk("R9 status set", v, 32'h1D);
        chk("R9 irq masked", {31'b0, irq}, 0);
        wr(4'h1, 32'd5);
        rd(4'h1, v); chk("R13 busy write ignored", v, 0);
        cmp_stream("R2 final stream");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule